// File: doc/BRIEF.md
# DDS Tuning Register Write Decoder

This block sits behind the serial front end of a direct digital synthesizer. It takes 16-bit command words that have already been deserialized, each marked by a one-cycle valid strobe. It routes each word into the tuning state. That state is a control register, two 28-bit frequency-tuning words and two 12-bit phase offsets. The two top bits of a word pick the target. The remaining bits carry the payload.

Frequency words can be loaded in two ways, and a control bit picks between them.

- **Paired mode:** a word supplying the low 14 bits is held aside. The full 28-bit value is loaded in one step when the matching high word arrives.
- **Half mode:** each frequency register is two independent 14-bit halves. A second control bit chooses which half a single word writes.

The register contents, the paired-mode flag and a one-cycle update pulse go to the phase accumulator and the logic downstream.

Top module: `dds_tuning_decoder`

## Requirements
- R1: Bits 15:14 of a command word select the target: 00 control, 01 frequency word 0, 10 frequency word 1, 11 phase. A control write stores bits 13:0, and no other register changes. Every result appears on the outputs one clock after the edge that samples the valid word.
- R2: When control bit 13 is 0 (half mode), a frequency write stores bits 13:0 into one half of the selected register. Control bit 12 = 1 selects the upper half (bits 27:14), and 0 selects the lower half (bits 13:0). The other half is kept.
- R3: When control bit 13 is 1 (paired mode), the first frequency write is staged and changes no register. The next write to the same frequency address loads {its bits 13:0, staged bits} as bits 27:0. Control bit 12 has no effect in this mode. `paired_mode` shows control bit 13.
- R4: While a staged low half is pending, a write to any other target discards it. The next write to the frequency address starts a new pair.
- R5: A control write clears any pending staged half, including one that switches between paired and half mode. A later frequency write does not complete the discarded pair.
- R6: A phase write loads bits 11:0 into phase register 0 when bit 13 is 0, and into phase register 1 when bit 13 is 1. Bit 12 has no effect.
- R7: `reg_update` is high for exactly the one cycle after each word that loads a frequency or phase register. It stays low after control writes, after staged paired words and after idle cycles.
- R8: Reset clears every register, the pending state and the pulse. A word presented with `cmd_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Command word: target in 15:14, payload below |
| ctrl_word | output | 14 | Stored control bits (13 = paired, 12 = half select) |
| paired_mode | output | 1 | Control bit 13 |
| freq0 | output | 28 | Frequency tuning word 0 |
| freq1 | output | 28 | Frequency tuning word 1 |
| phase0 | output | 12 | Phase offset 0 |
| phase1 | output | 12 | Phase offset 1 |
| reg_update | output | 1 | Pulse after a frequency or phase register load |

## Verification
Every result of this block is due one clock after the rising edge that samples a valid word. This covers the register contents, the mode flag, the cleared pending state and the update pulse. The bench drives each word on a falling edge, holds it for exactly one cycle and reads all outputs on the next falling edge, half a period after the edge that loaded them. Where a pulse must be single, or a staged half must have been dropped, the bench waits one or more further falling edges before sampling. In each case the wait is the number of words or idle cycles the requirement names.

// File: rtl/dds_tuning_decoder.sv
module dds_tuning_decoder #(
  parameter int HALF_W  = 14,
  parameter int PHASE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [HALF_W+1:0]     cmd_word,
  output logic [HALF_W-1:0]     ctrl_word,
  output logic                  paired_mode,
  output logic [2*HALF_W-1:0]   freq0,
  output logic [2*HALF_W-1:0]   freq1,
  output logic [PHASE_W-1:0]    phase0,
  output logic [PHASE_W-1:0]    phase1,
  output logic                  reg_update
);
  localparam int FREQ_W  = 2 * HALF_W;
  localparam int WORD_W  = HALF_W + 2;
  localparam int MODE_B  = HALF_W - 1;
  localparam int HALF_B  = HALF_W - 2;
  localparam int PSEL_B  = HALF_W - 1;

  logic [HALF_W-1:0] ctrl_q;
  logic [FREQ_W-1:0] freq_q [2];
  logic [PHASE_W-1:0] ph_q [2];
  logic [HALF_W-1:0] stage_q;
  logic              pend_q, pend_sel_q, upd_q;

  wire [1:0]        tgt     = cmd_word[WORD_W-1 -: 2];
  wire [HALF_W-1:0] payload = cmd_word[HALF_W-1:0];
  wire is_ctrl  = cmd_valid && (tgt == 2'b00);
  wire is_freq  = cmd_valid && (tgt == 2'b01 || tgt == 2'b10);
  wire is_ph    = cmd_valid && (tgt == 2'b11);
  wire fsel     = tgt[1];
  wire paired   = ctrl_q[MODE_B];
  wire commit   = is_freq && paired && pend_q && (pend_sel_q == fsel);
  wire stage_in = is_freq && paired && !commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      freq_q[0]  <= '0;
      freq_q[1]  <= '0;
      ph_q[0]    <= '0;
      ph_q[1]    <= '0;
      stage_q    <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
      upd_q      <= 1'b0;
    end else begin
      upd_q <= (is_freq && !stage_in) || is_ph;
      if (is_ctrl) ctrl_q <= payload;
      if (cmd_valid) pend_q <= stage_in;
      if (stage_in) begin
        stage_q    <= payload;
        pend_sel_q <= fsel;
      end
      if (commit)
        freq_q[fsel] <= {payload, stage_q};
      else if (is_freq && !paired) begin
        if (ctrl_q[HALF_B]) freq_q[fsel][FREQ_W-1:HALF_W] <= payload;
        else                freq_q[fsel][HALF_W-1:0]      <= payload;
      end
      if (is_ph) ph_q[cmd_word[PSEL_B]] <= cmd_word[PHASE_W-1:0];
    end
  end

  assign ctrl_word   = ctrl_q;
  assign paired_mode = ctrl_q[MODE_B];
  assign freq0       = freq_q[0];
  assign freq1       = freq_q[1];
  assign phase0      = ph_q[0];
  assign phase1      = ph_q[1];
  assign reg_update  = upd_q;

  // R1
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b00) |=> $stable(ctrl_word));
  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b01 && paired_mode && !pend_q) |=> $stable(freq0));
  // R4
  stage_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b11) |=> !pend_q);
  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b11) |=> ($stable(phase0) && $stable(phase1)));
  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_update |-> ($past(cmd_valid) && $past(cmd_word[WORD_W-1 -: 2]) != 2'b00));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(freq0) && $stable(freq1) && $stable(ctrl_word) && !reg_update));
endmodule

// File: tb/dds_tuning_decoder_tb.sv
module dds_tuning_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [13:0] ctrl_word;
  logic paired_mode, reg_update;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dds_tuning_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ctrl_word(ctrl_word), .paired_mode(paired_mode), .freq0(freq0), .freq1(freq1),
    .phase0(phase0), .phase1(phase1), .reg_update(reg_update));

  typedef struct packed {
    logic [15:0] w;
    logic [27:0] f0, f1;
    logic [11:0] p0, p1;
    logic        upd, mode;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{16'h1000, 28'h0,       28'h0,       12'h0,   12'h0,   1'b0, 1'b0, 4'd1}, // R1 ctrl: half, upper
    '{16'h40FF, 28'h03FC000, 28'h0,       12'h0,   12'h0,   1'b1, 1'b0, 4'd2}, // R2 upper half f0
    '{16'h0000, 28'h03FC000, 28'h0,       12'h0,   12'h0,   1'b0, 1'b0, 4'd1}, // R1 ctrl: lower
    '{16'hBFFF, 28'h03FC000, 28'h0003FFF, 12'h0,   12'h0,   1'b1, 1'b0, 4'd2}, // R2 lower half f1
    '{16'h2000, 28'h03FC000, 28'h0003FFF, 12'h0,   12'h0,   1'b0, 1'b1, 4'd3}, // R3 paired on
    '{16'h4000, 28'h03FC000, 28'h0003FFF, 12'h0,   12'h0,   1'b0, 1'b1, 4'd3}, // R3 stage
    '{16'h7FFF, 28'hFFFC000, 28'h0003FFF, 12'h0,   12'h0,   1'b1, 1'b1, 4'd3}, // R3 commit
    '{16'hC123, 28'hFFFC000, 28'h0003FFF, 12'h123, 12'h0,   1'b1, 1'b1, 4'd6}, // R6 phase0
    '{16'hF456, 28'hFFFC000, 28'h0003FFF, 12'h123, 12'h456, 1'b1, 1'b1, 4'd6}, // R6 phase1, bit12 set
    '{16'h8AAA, 28'hFFFC000, 28'h0003FFF, 12'h123, 12'h456, 1'b0, 1'b1, 4'd3}, // R3 stage f1
    '{16'hC001, 28'hFFFC000, 28'h0003FFF, 12'h001, 12'h456, 1'b1, 1'b1, 4'd4}, // R4 other target drops
    '{16'h9555, 28'hFFFC000, 28'h0003FFF, 12'h001, 12'h456, 1'b0, 1'b1, 4'd4}, // R4 new pair starts
    '{16'hA00F, 28'hFFFC000, 28'h803D555, 12'h001, 12'h456, 1'b1, 1'b1, 4'd4}, // R4 commit new pair
    '{16'h3000, 28'hFFFC000, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b1, 4'd3}, // R3 HLB set, paired
    '{16'h4ABC, 28'hFFFC000, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b1, 4'd3}, // R3 stage
    '{16'h4DEF, 28'h37BCABC, 28'h803D555, 12'h001, 12'h456, 1'b1, 1'b1, 4'd3}, // R3 HLB ignored
    '{16'h4001, 28'h37BCABC, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b1, 4'd5}, // R5 stage
    '{16'h0000, 28'h37BCABC, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b0, 4'd5}, // R5 mode change
    '{16'h4002, 28'h37BC002, 28'h803D555, 12'h001, 12'h456, 1'b1, 1'b0, 4'd5}  // R5 no stale commit
  };

  task automatic check_all(string req, logic [27:0] f0, logic [27:0] f1,
                           logic [11:0] p0, logic [11:0] p1, logic upd, logic mode);
    tests++;
    if (freq0 !== f0 || freq1 !== f1 || phase0 !== p0 || phase1 !== p1 ||
        reg_update !== upd || paired_mode !== mode) begin
      fails++;
      $display("FAIL %s: got f0=%h f1=%h p0=%h p1=%h upd=%b mode=%b exp f0=%h f1=%h p0=%h p1=%h upd=%b mode=%b",
               req, freq0, freq1, phase0, phase1, reg_update, paired_mode,
               f0, f1, p0, p1, upd, mode);
    end
  endtask

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check_all("R8 reset", 28'h0, 28'h0, 12'h0, 12'h0, 1'b0, 1'b0);
    tests++;
    if (ctrl_word !== 14'h0) begin
      fails++;
      $display("FAIL R8 reset ctrl: got %h exp 0", ctrl_word);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].w);
      check_all($sformatf("R%0d vec %0d", VEC[i].req, i),
                VEC[i].f0, VEC[i].f1, VEC[i].p0, VEC[i].p1, VEC[i].upd, VEC[i].mode);
    end

    // R7 pulse lasts one cycle
    @(negedge clk);
    check_all("R7 single pulse", 28'h37BC002, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b0);

    // R1 control stores bits 13:0
    send(16'h2ABC);
    tests++;
    if (ctrl_word !== 14'h2ABC) begin
      fails++;
      $display("FAIL R1 ctrl store: got %h exp 2abc", ctrl_word);
    end

    // R8 word with valid low ignored
    @(negedge clk);
    cmd_word = 16'hFFFF;
    @(negedge clk);
    cmd_word = 16'h4123;
    @(negedge clk);
    check_all("R8 valid low", 28'h37BC002, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b1);

    // R5 control write keeping paired mode still drops stage
    send(16'h8111);
    send(16'h2000);
    send(16'h8222);
    check_all("R5 drop stage", 28'h37BC002, 28'h803D555, 12'h001, 12'h456, 1'b0, 1'b1);
    send(16'h8333);
    check_all("R5 fresh pair", 28'h37BC002, 28'h0CCC222, 12'h001, 12'h456, 1'b1, 1'b1);

    // R3 cross-register: f1 stage then f0 word restarts pair on f0
    send(16'h8005);
    send(16'h4007);
    check_all("R3 cross reg", 28'h37BC002, 28'h0CCC222, 12'h001, 12'h456, 1'b0, 1'b1);
    send(16'h4009);
    check_all("R3 cross commit", 28'h0024007, 28'h0CCC222, 12'h001, 12'h456, 1'b1, 1'b1);

    // R8 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R8 mid reset", 28'h0, 28'h0, 12'h0, 12'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule